// File: doc/BRIEF.md
# Tagged Translation Buffer with Tree Replacement

This block caches recent virtual-to-physical page translations for a small set of address spaces. It is fully associative. Every slot holds a virtual page number, a physical page number, an address-space tag, a presence bit, separate read/write permissions for kernel and user mode, and cacheable, referenced and modified flags. A lookup is matched against the page number and the requester's current address-space tag. Switching between address spaces therefore needs no flush.

A lookup request is evaluated combinationally against the stored slots. The verdict is registered and appears one cycle later as exactly one of four outcomes: hit, miss, page fault or protection fault. On a miss, the page-table walker returns the entry through the fill port. A fill reuses a slot already holding the same page and tag, or else takes the lowest free slot, or else evicts the slot chosen by a binary-tree pseudo-LRU. The page-table maintenance code uses two controls: a single-entry invalidate to retire one stale mapping, and a flush-all control for running without tags.

Top module: `page_xlat_buf`

## Requirements
- R1: After reset no slot is occupied, so every lookup misses, and `rsp_valid_o` stays low in any cycle that follows a cycle without `lk_req_i`.
- R2: A lookup whose page number and tag both equal an occupied slot's, with a present page and the permission granted, reports a hit with that slot's physical page and cacheable flag. A lookup that differs in tag alone misses. `rsp_ppn_o` is zero on every non-hit.
- R3: A match on a slot whose presence bit is clear reports a page fault, whatever the permissions are.
- R4: Permission fields are 2 bits: bit 0 grants read and bit 1 grants write. User-mode lookups (`lk_user_i`=1) use the user field and kernel lookups use the kernel field. A present match without the needed grant reports a protection fault.
- R5: A lookup in cycle t is answered in cycle t+1 with `rsp_valid_o` high and exactly one of the four outcome flags set. All outcome flags are low when `rsp_valid_o` is low.
- R6: `rsp_ref_o` and `rsp_mod_o` report the hit slot's referenced and modified flags as they were before that access. A hit sets the referenced flag, a write hit also sets the modified flag, and a fill clears both.
- R7: A fill with no matching slot goes to the lowest-numbered unoccupied slot when one exists.
- R8: When all 8 slots are occupied, a fill evicts the pseudo-LRU victim. The tree has 7 node bits, heap-ordered, with the children of node n at 2n+1 and 2n+2 and slot i at leaf 7+i. The victim is found by following each node bit from the root (0 goes to the left child, 1 to the right). Every hit and fill sets the nodes on the slot's path to point away from it, applying a hit before a fill in the same cycle. Reset clears all node bits.
- R9: A fill whose page number and tag equal an occupied slot's overwrites that slot and never creates a second copy.
- R10: A single-entry invalidate clears only the slot matching both its page number and its tag.
- R11: Flush-all clears every slot. In one cycle, flush-all takes priority over invalidate, and invalidate takes priority over fill, so a fill issued with either is dropped.
- R12: A lookup sees the slot contents from before any fill, invalidate or flush issued in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lk_req_i | input | 1 | Lookup request |
| lk_vpn_i | input | VPN_W | Lookup virtual page number |
| lk_tag_i | input | TAG_W | Current address-space tag |
| lk_write_i | input | 1 | Access is a write |
| lk_user_i | input | 1 | Access is in user mode |
| fill_i | input | 1 | Fill request |
| fill_vpn_i | input | VPN_W | Fill virtual page number |
| fill_tag_i | input | TAG_W | Fill address-space tag |
| fill_ppn_i | input | PPN_W | Fill physical page number |
| fill_present_i | input | 1 | Page is present |
| fill_kperm_i | input | 2 | Kernel permissions (bit0 read, bit1 write) |
| fill_uperm_i | input | 2 | User permissions (bit0 read, bit1 write) |
| fill_cache_i | input | 1 | Page is cacheable |
| inv_one_i | input | 1 | Invalidate the matching slot |
| inv_vpn_i | input | VPN_W | Invalidate page number |
| inv_tag_i | input | TAG_W | Invalidate tag |
| flush_all_i | input | 1 | Invalidate every slot |
| rsp_valid_o | output | 1 | Lookup verdict valid |
| rsp_hit_o | output | 1 | Translation hit |
| rsp_miss_o | output | 1 | No matching slot |
| rsp_pfault_o | output | 1 | Matched page not present |
| rsp_prot_o | output | 1 | Permission denied |
| rsp_ppn_o | output | PPN_W | Physical page on hit, else zero |
| rsp_cache_o | output | 1 | Cacheable flag on hit |
| rsp_ref_o | output | 1 | Referenced flag before the access |
| rsp_mod_o | output | 1 | Modified flag before the access |

## Verification
A corrupted slot field shows at the ports on the next lookup of that page: a wrong page number, a hit that should miss, or a fault of the wrong kind, one cycle after the request. A wrong replacement-tree bit stays hidden until the buffer is full. After the next fill it appears as the wrong page going missing, so the bench runs long mixed sequences of fills and lookups over a full buffer and compares every lookup with an arithmetic model. Lost referenced or modified updates appear one access later through the reported prior flags.

// File: rtl/pxb_pkg.sv
package pxb_pkg;
  typedef enum logic [1:0] {
    OUT_MISS   = 2'd0,
    OUT_HIT    = 2'd1,
    OUT_PFAULT = 2'd2,
    OUT_PROT   = 2'd3
  } pxb_outcome_e;

  localparam int unsigned PERM_RD = 0;
  localparam int unsigned PERM_WR = 1;
endpackage

// File: rtl/pxb_cam.sv
module pxb_cam #(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned VPN_W   = 20,
  parameter int unsigned TAG_W   = 8
) (
  input  logic [ENTRIES-1:0]            used_i,
  input  logic [ENTRIES-1:0][VPN_W-1:0] vpn_i,
  input  logic [ENTRIES-1:0][TAG_W-1:0] tag_i,
  input  logic [VPN_W-1:0]              key_vpn_i,
  input  logic [TAG_W-1:0]              key_tag_i,
  output logic [ENTRIES-1:0]            match_o
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match_o[g] = used_i[g] && (vpn_i[g] == key_vpn_i) && (tag_i[g] == key_tag_i);
  end
endmodule

// File: rtl/pxb_prio.sv
module pxb_prio #(
  parameter int unsigned N  = 8,
  parameter int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i);
    end
  end
  assign found_o = |req_i;
endmodule

// File: rtl/pxb_plru.sv
// Binary tree pseudo-LRU; N must be a power of two, at least 2.
module pxb_plru #(
  parameter int unsigned N  = 8,
  parameter int unsigned IW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          touch_a_i,
  input  logic [IW-1:0] touch_a_idx_i,
  input  logic          touch_b_i,
  input  logic [IW-1:0] touch_b_idx_i,
  output logic [IW-1:0] victim_o
);
  logic [N-2:0] state_q, state_d;

  function automatic logic [N-2:0] point_away(input logic [N-2:0] s, input logic [IW-1:0] idx);
    logic [N-2:0] r;
    int node;
    r = s;
    for (int l = 0; l < int'(IW); l++) begin
      node = (1 << l) - 1 + int'(idx >> (IW - l));
      r[node] = ~idx[IW-1-l];
    end
    return r;
  endfunction

  always_comb begin
    state_d = state_q;
    if (touch_a_i) state_d = point_away(state_d, touch_a_idx_i);
    if (touch_b_i) state_d = point_away(state_d, touch_b_idx_i);
  end

  always_comb begin
    int node;
    node = 0;
    for (int l = 0; l < int'(IW); l++) begin
      node = 2 * node + 1 + int'(state_q[node]);
    end
    victim_o = IW'(node - int'(N - 1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= '0;
    else         state_q <= state_d;
  end
endmodule

// File: rtl/page_xlat_buf.sv
module page_xlat_buf
  import pxb_pkg::*;
#(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned VPN_W   = 20,
  parameter int unsigned PPN_W   = 20,
  parameter int unsigned TAG_W   = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lk_req_i,
  input  logic [VPN_W-1:0] lk_vpn_i,
  input  logic [TAG_W-1:0] lk_tag_i,
  input  logic             lk_write_i,
  input  logic             lk_user_i,
  input  logic             fill_i,
  input  logic [VPN_W-1:0] fill_vpn_i,
  input  logic [TAG_W-1:0] fill_tag_i,
  input  logic [PPN_W-1:0] fill_ppn_i,
  input  logic             fill_present_i,
  input  logic [1:0]       fill_kperm_i,
  input  logic [1:0]       fill_uperm_i,
  input  logic             fill_cache_i,
  input  logic             inv_one_i,
  input  logic [VPN_W-1:0] inv_vpn_i,
  input  logic [TAG_W-1:0] inv_tag_i,
  input  logic             flush_all_i,
  output logic             rsp_valid_o,
  output logic             rsp_hit_o,
  output logic             rsp_miss_o,
  output logic             rsp_pfault_o,
  output logic             rsp_prot_o,
  output logic [PPN_W-1:0] rsp_ppn_o,
  output logic             rsp_cache_o,
  output logic             rsp_ref_o,
  output logic             rsp_mod_o
);
  localparam int unsigned IW = $clog2(ENTRIES);

  logic [ENTRIES-1:0]            used_q, pres_q, ref_q, mod_q, cach_q;
  logic [ENTRIES-1:0][VPN_W-1:0] vpn_q;
  logic [ENTRIES-1:0][TAG_W-1:0] tag_q;
  logic [ENTRIES-1:0][PPN_W-1:0] ppn_q;
  logic [ENTRIES-1:0][1:0]       kperm_q, uperm_q;

  logic [ENTRIES-1:0] lk_match, fill_match, inv_match;
  logic               lk_found, fill_found, free_found;
  logic [IW-1:0]      lk_idx, fill_hit_idx, free_idx, victim_idx, fill_idx;
  logic [1:0]         lk_perm;
  logic               lk_allow, lk_ok, fill_go;
  pxb_outcome_e       lk_out;

  pxb_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .TAG_W(TAG_W)) u_cam_lk (
    .used_i(used_q), .vpn_i(vpn_q), .tag_i(tag_q),
    .key_vpn_i(lk_vpn_i), .key_tag_i(lk_tag_i), .match_o(lk_match));
  pxb_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .TAG_W(TAG_W)) u_cam_fill (
    .used_i(used_q), .vpn_i(vpn_q), .tag_i(tag_q),
    .key_vpn_i(fill_vpn_i), .key_tag_i(fill_tag_i), .match_o(fill_match));
  pxb_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .TAG_W(TAG_W)) u_cam_inv (
    .used_i(used_q), .vpn_i(vpn_q), .tag_i(tag_q),
    .key_vpn_i(inv_vpn_i), .key_tag_i(inv_tag_i), .match_o(inv_match));

  pxb_prio #(.N(ENTRIES)) u_prio_lk   (.req_i(lk_match),   .found_o(lk_found),   .idx_o(lk_idx));
  pxb_prio #(.N(ENTRIES)) u_prio_fill (.req_i(fill_match), .found_o(fill_found), .idx_o(fill_hit_idx));
  pxb_prio #(.N(ENTRIES)) u_prio_free (.req_i(~used_q),    .found_o(free_found), .idx_o(free_idx));

  // lookup verdict, fault ordering: absent page before permission
  assign lk_perm  = lk_user_i ? uperm_q[lk_idx] : kperm_q[lk_idx];
  assign lk_allow = lk_write_i ? lk_perm[PERM_WR] : lk_perm[PERM_RD];

  always_comb begin
    if (!lk_found)             lk_out = OUT_MISS;
    else if (!pres_q[lk_idx])  lk_out = OUT_PFAULT;
    else if (!lk_allow)        lk_out = OUT_PROT;
    else                       lk_out = OUT_HIT;
  end

  assign lk_ok   = lk_req_i && (lk_out == OUT_HIT);
  assign fill_go = fill_i && !flush_all_i && !inv_one_i;
  assign fill_idx = fill_found ? fill_hit_idx : (free_found ? free_idx : victim_idx);

  pxb_plru #(.N(ENTRIES)) u_plru (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .touch_a_i(lk_ok),   .touch_a_idx_i(lk_idx),
    .touch_b_i(fill_go), .touch_b_idx_i(fill_idx),
    .victim_o(victim_idx));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      used_q  <= '0;
      pres_q  <= '0;
      ref_q   <= '0;
      mod_q   <= '0;
      cach_q  <= '0;
      vpn_q   <= '0;
      tag_q   <= '0;
      ppn_q   <= '0;
      kperm_q <= '0;
      uperm_q <= '0;
    end else begin
      for (int i = 0; i < int'(ENTRIES); i++) begin
        if (flush_all_i) begin
          used_q[i] <= 1'b0;
        end else if (inv_one_i && inv_match[i]) begin
          used_q[i] <= 1'b0;
        end else if (fill_go && fill_idx == IW'(i)) begin
          used_q[i]  <= 1'b1;
          vpn_q[i]   <= fill_vpn_i;
          tag_q[i]   <= fill_tag_i;
          ppn_q[i]   <= fill_ppn_i;
          pres_q[i]  <= fill_present_i;
          kperm_q[i] <= fill_kperm_i;
          uperm_q[i] <= fill_uperm_i;
          cach_q[i]  <= fill_cache_i;
          ref_q[i]   <= 1'b0;
          mod_q[i]   <= 1'b0;
        end else if (lk_ok && lk_idx == IW'(i)) begin
          ref_q[i] <= 1'b1;
          if (lk_write_i) mod_q[i] <= 1'b1;
        end
      end
    end
  end

  logic             rsp_valid_q;
  pxb_outcome_e     rsp_out_q;
  logic [PPN_W-1:0] rsp_ppn_q;
  logic             rsp_cache_q, rsp_ref_q, rsp_mod_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= 1'b0;
      rsp_out_q   <= OUT_MISS;
      rsp_ppn_q   <= '0;
      rsp_cache_q <= 1'b0;
      rsp_ref_q   <= 1'b0;
      rsp_mod_q   <= 1'b0;
    end else begin
      rsp_valid_q <= lk_req_i;
      rsp_out_q   <= lk_out;
      rsp_ppn_q   <= lk_ok ? ppn_q[lk_idx]  : '0;
      rsp_cache_q <= lk_ok ? cach_q[lk_idx] : 1'b0;
      rsp_ref_q   <= lk_ok ? ref_q[lk_idx]  : 1'b0;
      rsp_mod_q   <= lk_ok ? mod_q[lk_idx]  : 1'b0;
    end
  end

  assign rsp_valid_o  = rsp_valid_q;
  assign rsp_hit_o    = rsp_valid_q && (rsp_out_q == OUT_HIT);
  assign rsp_miss_o   = rsp_valid_q && (rsp_out_q == OUT_MISS);
  assign rsp_pfault_o = rsp_valid_q && (rsp_out_q == OUT_PFAULT);
  assign rsp_prot_o   = rsp_valid_q && (rsp_out_q == OUT_PROT);
  assign rsp_ppn_o    = rsp_ppn_q;
  assign rsp_cache_o  = rsp_cache_q;
  assign rsp_ref_o    = rsp_ref_q;
  assign rsp_mod_o    = rsp_mod_q;
endmodule

// File: rtl/pxb_checker.sv
module pxb_checker #(
  parameter int unsigned VPN_W = 20,
  parameter int unsigned PPN_W = 20,
  parameter int unsigned TAG_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             lk_req_i,
  input logic [VPN_W-1:0] lk_vpn_i,
  input logic [TAG_W-1:0] lk_tag_i,
  input logic             lk_write_i,
  input logic             lk_user_i,
  input logic             fill_i,
  input logic [VPN_W-1:0] fill_vpn_i,
  input logic [TAG_W-1:0] fill_tag_i,
  input logic [PPN_W-1:0] fill_ppn_i,
  input logic             fill_present_i,
  input logic [1:0]       fill_kperm_i,
  input logic             inv_one_i,
  input logic             flush_all_i,
  input logic             rsp_valid_o,
  input logic             rsp_hit_o,
  input logic             rsp_miss_o,
  input logic             rsp_pfault_o,
  input logic             rsp_prot_o,
  input logic [PPN_W-1:0] rsp_ppn_o
);
  assert_one_outcome_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $countones({rsp_hit_o, rsp_miss_o, rsp_pfault_o, rsp_prot_o}) == 1);

  assert_answer_follows_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_req_i |=> rsp_valid_o);

  assert_quiet_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_req_i |=> !(rsp_valid_o || rsp_hit_o || rsp_miss_o || rsp_pfault_o || rsp_prot_o));

  assert_ppn_zero_miss_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_hit_o |-> rsp_ppn_o == '0);

  assert_flush_empties_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_all_i ##1 lk_req_i |=> rsp_miss_o);

  assert_fill_then_hit_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_i && !flush_all_i && !inv_one_i && fill_present_i) ##1
    (lk_req_i && !lk_user_i && lk_vpn_i == $past(fill_vpn_i) && lk_tag_i == $past(fill_tag_i)
     && (lk_write_i ? $past(fill_kperm_i[1]) : $past(fill_kperm_i[0])))
    |=> (rsp_hit_o && rsp_ppn_o == $past(fill_ppn_i, 2)));

  assert_absent_faults_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_i && !flush_all_i && !inv_one_i && !fill_present_i) ##1
    (lk_req_i && lk_vpn_i == $past(fill_vpn_i) && lk_tag_i == $past(fill_tag_i))
    |=> rsp_pfault_o);
endmodule

bind page_xlat_buf pxb_checker #(.VPN_W(VPN_W), .PPN_W(PPN_W), .TAG_W(TAG_W)) u_pxb_checker (.*);

// File: tb/page_xlat_buf_bench.sv
module page_xlat_buf_bench;
  localparam int CLK_PERIOD = 10;
  localparam int E = 8;
  localparam int LV = 3;
  localparam int VW = 20;
  localparam int PW = 20;
  localparam int TW = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic          lk_req, lk_write, lk_user, fill, fill_present, fill_cache, inv_one, flush_all;
  logic [VW-1:0] lk_vpn, fill_vpn, inv_vpn;
  logic [TW-1:0] lk_tag, fill_tag, inv_tag;
  logic [PW-1:0] fill_ppn;
  logic [1:0]    fill_kperm, fill_uperm;
  logic          rsp_valid, rsp_hit, rsp_miss, rsp_pfault, rsp_prot, rsp_cache, rsp_ref, rsp_mod;
  logic [PW-1:0] rsp_ppn;

  page_xlat_buf u_page_xlat_buf (
    .clk_i(clk), .rst_ni(rst_ni),
    .lk_req_i(lk_req), .lk_vpn_i(lk_vpn), .lk_tag_i(lk_tag), .lk_write_i(lk_write), .lk_user_i(lk_user),
    .fill_i(fill), .fill_vpn_i(fill_vpn), .fill_tag_i(fill_tag), .fill_ppn_i(fill_ppn),
    .fill_present_i(fill_present), .fill_kperm_i(fill_kperm), .fill_uperm_i(fill_uperm),
    .fill_cache_i(fill_cache), .inv_one_i(inv_one), .inv_vpn_i(inv_vpn), .inv_tag_i(inv_tag),
    .flush_all_i(flush_all),
    .rsp_valid_o(rsp_valid), .rsp_hit_o(rsp_hit), .rsp_miss_o(rsp_miss), .rsp_pfault_o(rsp_pfault),
    .rsp_prot_o(rsp_prot), .rsp_ppn_o(rsp_ppn), .rsp_cache_o(rsp_cache), .rsp_ref_o(rsp_ref),
    .rsp_mod_o(rsp_mod));

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  string cur_req = "R1";

  // reference model
  bit          m_used[E], m_pres[E], m_ref[E], m_mod[E], m_cach[E];
  bit [VW-1:0] m_vpn[E];
  bit [TW-1:0] m_tag[E];
  bit [PW-1:0] m_ppn[E];
  bit [1:0]    m_kp[E], m_up[E];
  bit          m_tree[E-1];

  function automatic int find(bit [VW-1:0] v, bit [TW-1:0] t);
    for (int i = 0; i < E; i++) if (m_used[i] && m_vpn[i] == v && m_tag[i] == t) return i;
    return -1;
  endfunction

  function automatic void touch(int idx);
    for (int l = 0; l < LV; l++) m_tree[(1 << l) - 1 + (idx >> (LV - l))] = ~((idx >> (LV - 1 - l)) & 1);
  endfunction

  function automatic int victim();
    int node = 0;
    for (int l = 0; l < LV; l++) node = 2 * node + 1 + int'(m_tree[node]);
    return node - (E - 1);
  endfunction

  task automatic chk(bit ok, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", cur_req, act, exp);
    end
  endtask

  task automatic clear_in();
    lk_req = 0; lk_write = 0; lk_user = 0; lk_vpn = '0; lk_tag = '0;
    fill = 0; fill_vpn = '0; fill_tag = '0; fill_ppn = '0; fill_present = 0;
    fill_kperm = '0; fill_uperm = '0; fill_cache = 0;
    inv_one = 0; inv_vpn = '0; inv_tag = '0; flush_all = 0;
  endtask

  task automatic set_lk(bit [VW-1:0] v, bit [TW-1:0] t, bit wr, bit usr);
    lk_req = 1; lk_vpn = v; lk_tag = t; lk_write = wr; lk_user = usr;
  endtask

  task automatic set_fill(bit [VW-1:0] v, bit [TW-1:0] t, bit [PW-1:0] p, bit pres,
                          bit [1:0] kp, bit [1:0] up, bit c);
    fill = 1; fill_vpn = v; fill_tag = t; fill_ppn = p; fill_present = pres;
    fill_kperm = kp; fill_uperm = up; fill_cache = c;
  endtask

  // one clock: expectation from pre-state, model update, compare after the edge
  task automatic step();
    bit [3:0] e_flags = 4'b0000;
    bit [PW-1:0] e_ppn = '0;
    bit e_c = 0, e_r = 0, e_m = 0;
    int mi, tgt;
    bit [1:0] perm;
    bit hit = 0;
    bit do_lk = lk_req;
    mi = find(lk_vpn, lk_tag);
    if (do_lk) begin
      if (mi < 0) e_flags = 4'b0100;
      else if (!m_pres[mi]) e_flags = 4'b0010;
      else begin
        perm = lk_user ? m_up[mi] : m_kp[mi];
        if (lk_write ? perm[1] : perm[0]) begin
          e_flags = 4'b1000; hit = 1;
          e_ppn = m_ppn[mi]; e_c = m_cach[mi]; e_r = m_ref[mi]; e_m = m_mod[mi];
        end else e_flags = 4'b0001;
      end
    end
    tgt = find(fill_vpn, fill_tag);
    if (tgt < 0) for (int i = E - 1; i >= 0; i--) if (!m_used[i]) tgt = i;
    if (tgt < 0) tgt = victim();
    if (hit) begin
      m_ref[mi] = 1;
      if (lk_write) m_mod[mi] = 1;
      touch(mi);
    end
    if (flush_all) begin
      for (int i = 0; i < E; i++) m_used[i] = 0;
    end else if (inv_one) begin
      for (int i = 0; i < E; i++) if (m_used[i] && m_vpn[i] == inv_vpn && m_tag[i] == inv_tag) m_used[i] = 0;
    end else if (fill) begin
      m_used[tgt] = 1; m_vpn[tgt] = fill_vpn; m_tag[tgt] = fill_tag; m_ppn[tgt] = fill_ppn;
      m_pres[tgt] = fill_present; m_kp[tgt] = fill_kperm; m_up[tgt] = fill_uperm;
      m_cach[tgt] = fill_cache; m_ref[tgt] = 0; m_mod[tgt] = 0;
      touch(tgt);
    end
    @(posedge clk);
    @(negedge clk);
    chk({rsp_valid, rsp_hit, rsp_miss, rsp_pfault, rsp_prot, rsp_cache, rsp_ref, rsp_mod, rsp_ppn} ==
        {do_lk, e_flags, e_c, e_r, e_m, e_ppn},
        {4'h0, rsp_valid, rsp_hit, rsp_miss, rsp_pfault, rsp_prot, rsp_cache, rsp_ref, rsp_mod, rsp_ppn},
        {4'h0, do_lk, e_flags, e_c, e_r, e_m, e_ppn});
    clear_in();
  endtask

  task automatic lookup(bit [VW-1:0] v, bit [TW-1:0] t, bit wr, bit usr);
    set_lk(v, t, wr, usr); step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    bit [31:0] x;
    clear_in();
    for (int i = 0; i < E; i++) m_used[i] = 0;
    for (int i = 0; i < E - 1; i++) m_tree[i] = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1;

    // R1: idle then empty lookups
    cur_req = "R1";
    step();
    lookup(20'h0, 8'h0, 0, 0);
    lookup(20'h00100, 8'h03, 1, 1);

    // R7: fill free slots, then reuse a freed one
    cur_req = "R7";
    for (int i = 0; i < E; i++) begin
      set_fill(20'h00100 + 20'(i), 8'h03, 20'h05000 + 20'(i * 7), 1, 2'b11, 2'b11, i[0]); step();
    end
    cur_req = "R2";
    for (int i = 0; i < E; i++) begin
      lookup(20'h00100 + 20'(i), 8'h03, 0, 1);
      lookup(20'h00100 + 20'(i), 8'h04, 0, 1);  // tag differs: miss
    end
    cur_req = "R10";
    inv_one = 1; inv_vpn = 20'h00103; inv_tag = 8'h04; step();   // wrong tag, no effect
    lookup(20'h00103, 8'h03, 0, 0);
    inv_one = 1; inv_vpn = 20'h00103; inv_tag = 8'h03; step();
    lookup(20'h00103, 8'h03, 0, 0);
    cur_req = "R7";
    set_fill(20'h00777, 8'h03, 20'h0abcd, 1, 2'b11, 2'b01, 1); step();
    for (int i = 0; i < E; i++) lookup(20'h00100 + 20'(i), 8'h03, 0, 0);
    lookup(20'h00777, 8'h03, 0, 1);

    // R8: long mixed sequence over a full buffer
    cur_req = "R8";
    flush_all = 1; step();
    x = 32'h1234_5678;
    for (int it = 0; it < 400; it++) begin
      x = x * 32'd1103515245 + 32'd12345;
      if (((x >> 8) & 3) == 0)
        set_fill(20'h00200 + 20'((x >> 16) % 12), 8'h05, 20'((x >> 4) & 32'hfffff), 1, 2'b11, 2'b11, x[20]);
      else
        set_lk(20'h00200 + 20'((x >> 16) % 12), 8'h05, x[21], x[22]);
      step();
    end
    for (int v = 0; v < 12; v++) lookup(20'h00200 + 20'(v), 8'h05, 0, 0);

    // R3: absent page faults regardless of permission
    cur_req = "R3";
    set_fill(20'h00300, 8'h01, 20'h11111, 0, 2'b00, 2'b00, 0); step();
    lookup(20'h00300, 8'h01, 0, 0);
    lookup(20'h00300, 8'h01, 1, 1);

    // R4: every permission pair, mode and access kind; refills hit in place (R9)
    cur_req = "R4";
    for (int kp = 0; kp < 4; kp++)
      for (int up = 0; up < 4; up++) begin
        set_fill(20'h00300, 8'h01, 20'h22220 + 20'(kp * 4 + up), 1, 2'(kp), 2'(up), 1); step();
        for (int m = 0; m < 4; m++) lookup(20'h00300, 8'h01, m[0], m[1]);
      end

    // R6: prior reference and modify flags
    cur_req = "R6";
    set_fill(20'h00400, 8'h02, 20'h33333, 1, 2'b11, 2'b11, 0); step();
    lookup(20'h00400, 8'h02, 0, 0);
    lookup(20'h00400, 8'h02, 0, 0);
    lookup(20'h00400, 8'h02, 1, 0);
    lookup(20'h00400, 8'h02, 0, 1);
    set_fill(20'h00400, 8'h02, 20'h33334, 1, 2'b11, 2'b11, 0); step();
    lookup(20'h00400, 8'h02, 0, 0);

    // R9: overwrite in place, then fill the rest and sweep
    cur_req = "R9";
    flush_all = 1; step();
    set_fill(20'h00500, 8'h07, 20'h0aaaa, 1, 2'b11, 2'b11, 0); step();
    set_fill(20'h00500, 8'h07, 20'h0bbbb, 1, 2'b11, 2'b11, 1); step();
    lookup(20'h00500, 8'h07, 0, 0);
    for (int i = 1; i < E; i++) begin
      set_fill(20'h00500 + 20'(i), 8'h07, 20'h0c000 + 20'(i), 1, 2'b11, 2'b11, 0); step();
    end
    for (int i = 0; i < E; i++) lookup(20'h00500 + 20'(i), 8'h07, 0, 0);

    // R11: flush and invalidate win over a same-cycle fill
    cur_req = "R11";
    flush_all = 1; set_fill(20'h00600, 8'h07, 20'h0dddd, 1, 2'b11, 2'b11, 0); step();
    lookup(20'h00600, 8'h07, 0, 0);
    lookup(20'h00501, 8'h07, 0, 0);
    inv_one = 1; inv_vpn = 20'h0; inv_tag = 8'h0;
    set_fill(20'h00601, 8'h07, 20'h0eeee, 1, 2'b11, 2'b11, 0); step();
    lookup(20'h00601, 8'h07, 0, 0);

    // R12: lookup sees state before a same-cycle fill
    cur_req = "R12";
    set_lk(20'h00602, 8'h07, 0, 0);
    set_fill(20'h00602, 8'h07, 20'h0f0f0, 1, 2'b11, 2'b11, 1); step();
    lookup(20'h00602, 8'h07, 0, 0);
    set_lk(20'h00602, 8'h07, 0, 0); flush_all = 1; step();
    lookup(20'h00602, 8'h07, 0, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule